// File: doc/BRIEF.md
# Quarter-Period Positive-Sequence Extractor

This block takes a stream of signed alpha/beta voltage samples from an unbalanced three-phase source and returns only the positive-sequence alpha/beta pair, one output per input sample. It sits ahead of a phase tracker, which then sees only the positive-sequence rotation. The negative-sequence part turns the other way. Delaying both axes by a quarter of the fundamental period shifts the positive part by -pi/2 and the negative part by +pi/2. A cross-coupled sum of present and delayed samples then cancels the negative part.

The quarter-period length is a fixed number of samples, `DEPTH`, equal to the sample rate times T/4. With a 50 Hz grid T/4 is 5 ms, so 10 kHz sampling gives 50. Each axis keeps its history in a circular buffer. Both buffers share one write pointer. Once per accepted sample the buffer returns the value written `DEPTH` samples earlier and stores the new one in its place.

A two-state controller tracks whether the history is valid. `FILL` is entered at reset and lasts until `DEPTH` samples have been accepted. The transition `FILL_DONE` fires on the sample that makes the write pointer wrap. After it the block sits in `RUN` until the next reset. In `FILL` the delayed terms count as zero and the output valid stays low.

Top module: `qps_extractor`

## Requirements
- R1: `out_valid` is high in the cycle after an accepted sample (`in_valid` high at a rising edge) only when the block is in `RUN`. It is never high in a cycle that does not follow an accepted sample.
- R2: After reset the first `DEPTH` accepted samples produce no `out_valid` pulse. Sample number `DEPTH` (counting from 0) is the first to produce one.
- R3: In `RUN`, `out_alpha` equals floor((alpha[n] - beta[n-DEPTH]) / 2). Here n counts accepted samples, not clock cycles.
- R4: In `RUN`, `out_beta` equals floor((alpha[n-DEPTH] + beta[n]) / 2).
- R5: Full-scale inputs do not wrap. The difference or sum is formed one bit wider than the data and then arithmetically shifted right by one. For 16-bit data, alpha = 32767 with a delayed beta of -32768 gives `out_alpha` = 32767. Delayed alpha = -32768 with beta = -32768 gives `out_beta` = -32768.
- R6: During `FILL`, the output data registers still load on each accepted sample, with the delayed terms taken as zero. They hold floor(alpha/2) and floor(beta/2).
- R7: Cycles with `in_valid` low change neither the outputs nor the history. The delay counts accepted samples only.
- R8: While `rst_n` is low, `out_valid`, `out_alpha` and `out_beta` are zero and the controller returns to `FILL`.
- R9: The write pointer moves by one per accepted sample and wraps from `DEPTH-1` to 0. The delay is therefore exactly `DEPTH` samples across every wrap.
- R10: For a balanced-plus-unbalanced input whose period is 4*`DEPTH` samples, the `RUN` output follows the positive-sequence component to within 2 LSB. The negative-sequence component is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe; one sample accepted per cycle it is high |
| in_alpha | input | DATA_W | Signed alpha-axis sample |
| in_beta | input | DATA_W | Signed beta-axis sample |
| out_valid | output | 1 | Positive-sequence pair valid, one cycle after an accepted sample in RUN |
| out_alpha | output | DATA_W | Signed positive-sequence alpha |
| out_beta | output | DATA_W | Signed positive-sequence beta |

## Verification
The bench targets the fill boundary. A controller that leaves `FILL` one sample early would pulse `out_valid` on an unwritten slot. One that leaves one sample late would drop the first valid pair. Full-scale opposite-sign inputs are driven so that a sum kept at data width wraps and flips sign. Idle gaps and a mid-run reset check two more faults: a pointer that counts cycles instead of samples would misalign the delayed terms, and stale history would leak into the next fill. A synthetic unbalanced sinusoid shows whether the cross-coupled signs are right: with a sign swapped, the negative sequence doubles instead of cancelling.

// File: rtl/qps_pkg.sv
package qps_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;
endpackage

// File: rtl/qps_wr_ptr.sv
module qps_wr_ptr #(
    parameter int DEPTH = 50,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          at_last
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign at_last = (ptr == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= at_last ? '0 : ptr + AW'(1);
        end
    end

    // R9: one slot per accepted sample, wrap to zero only from the last slot
    p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((ptr == $past(ptr) + AW'(1)) || (ptr == '0 && $past(ptr) == LAST)));
    // R7: idle cycles leave the pointer alone
    p_ptr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ptr));
endmodule

// File: rtl/qps_delay_line.sv
module qps_delay_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 50,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic signed [DATA_W-1:0] wr_data,
    output logic signed [DATA_W-1:0] old_data
);
    logic signed [DATA_W-1:0] mem [DEPTH];

    // read-before-write: the slot about to be overwritten holds the sample from DEPTH steps ago
    assign old_data = mem[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end
endmodule

// File: rtl/qps_combiner.sv
module qps_combiner #(
    parameter int DATA_W = 16,
    localparam int SW = DATA_W + 1
) (
    input  logic                     use_hist,
    input  logic signed [DATA_W-1:0] cur_a,
    input  logic signed [DATA_W-1:0] cur_b,
    input  logic signed [DATA_W-1:0] old_a,
    input  logic signed [DATA_W-1:0] old_b,
    output logic signed [DATA_W-1:0] pos_a,
    output logic signed [DATA_W-1:0] pos_b
);
    logic signed [DATA_W-1:0] da, db;
    logic signed [SW-1:0]     diff_a, sum_b;

    assign da = use_hist ? old_a : '0;
    assign db = use_hist ? old_b : '0;

    assign diff_a = SW'(cur_a) - SW'(db);
    assign sum_b  = SW'(da) + SW'(cur_b);

    // arithmetic halving of the widened value; the top bits always fit DATA_W
    assign pos_a = DATA_W'(diff_a >>> 1);
    assign pos_b = DATA_W'(sum_b >>> 1);
endmodule

// File: rtl/qps_extractor.sv
module qps_extractor
    import qps_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 50,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_alpha,
    input  logic signed [DATA_W-1:0] in_beta,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_alpha,
    output logic signed [DATA_W-1:0] out_beta
);
    fill_state_e state, state_nx;

    logic [AW-1:0]            wr_addr;
    logic                     wr_last;
    logic signed [DATA_W-1:0] cur_v [2];
    logic signed [DATA_W-1:0] old_v [2];
    logic signed [DATA_W-1:0] pos_a, pos_b;

    assign cur_v[0] = in_alpha;
    assign cur_v[1] = in_beta;

    qps_wr_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (in_valid),
        .ptr     (wr_addr),
        .at_last (wr_last)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_hist
        qps_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_line (
            .clk      (clk),
            .wr_en    (in_valid),
            .addr     (wr_addr),
            .wr_data  (cur_v[ch]),
            .old_data (old_v[ch])
        );
    end

    qps_combiner #(.DATA_W(DATA_W)) u_comb (
        .use_hist (state == ST_RUN),
        .cur_a    (in_alpha),
        .cur_b    (in_beta),
        .old_a    (old_v[0]),
        .old_b    (old_v[1]),
        .pos_a    (pos_a),
        .pos_b    (pos_b)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= state_nx;
        end
    end

    // next state: FILL_DONE on the sample that wraps the pointer
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: if (in_valid && wr_last) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_alpha <= '0;
            out_beta  <= '0;
        end else begin
            out_valid <= in_valid && (state == ST_RUN);
            if (in_valid) begin
                out_alpha <= pos_a;
                out_beta  <= pos_b;
            end
        end
    end

    // R1: a valid pulse always follows an accepted sample
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R2: nothing is announced while the history is incomplete
    p_fill_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |=> !out_valid);
    // R7: outputs hold through idle cycles
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_alpha) && $stable(out_beta)));
    // R2: RUN is never left without reset
    p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN));
endmodule

// File: tb/tb_qps_extractor.sv
module tb_qps_extractor;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int D = 12;
    localparam int MAXV = 32767;
    localparam int MINV = -32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_alpha = '0;
    logic signed [W-1:0] in_beta = '0;
    logic out_valid;
    logic signed [W-1:0] out_alpha, out_beta;

    int n_cmp = 0;
    int n_bad = 0;
    int n_acc = 0;
    int ha [0:1023];
    int hb [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    qps_extractor #(.DATA_W(W), .DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_alpha(in_alpha), .in_beta(in_beta),
        .out_valid(out_valid), .out_alpha(out_alpha), .out_beta(out_beta)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one accepted sample, checked at the next falling edge
    task automatic push(input int a, input int b);
        int da, db, ea, eb;
        bit ev;
        @(negedge clk);
        in_valid = 1'b1;
        in_alpha = W'(a);
        in_beta  = W'(b);
        ev = (n_acc >= D);
        da = ev ? ha[n_acc - D] : 0;
        db = ev ? hb[n_acc - D] : 0;
        ea = (a - db) >>> 1;
        eb = (da + b) >>> 1;
        ha[n_acc] = a;
        hb[n_acc] = b;
        n_acc++;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == ev, ev ? "R1 valid" : "R2 valid", int'(out_valid), int'(ev));
        chk(int'(out_alpha) == ea, ev ? "R3 alpha" : "R6 alpha", int'(out_alpha), ea);
        chk(int'(out_beta) == eb, ev ? "R4 beta" : "R6 beta", int'(out_beta), eb);
    endtask

    task automatic idle(input int k);
        int pa, pb;
        pa = int'(out_alpha);
        pb = int'(out_beta);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_alpha = W'(12345 + i);
            in_beta  = W'(-999 - i);
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 idle valid", int'(out_valid), 0);
            chk(int'(out_alpha) == pa && int'(out_beta) == pb, "R7 idle hold",
                int'(out_alpha), pa);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 valid", int'(out_valid), 0);
        chk(out_alpha == '0 && out_beta == '0, "R8 data", int'(out_alpha), 0);
        rst_n = 1'b1;
        n_acc = 0;
    endtask

    task automatic t_fill_and_ramp();
        for (int i = 0; i < 3 * D + 5; i++) push(100 * i - 1500, 777 - 53 * i);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 2 * D + 3; i++) begin
            push((i % 2) ? 4000 - i : -3001 + 7 * i, 211 * i - 2000);
            if (i % 4 == 1) idle(i % 3 + 1);
        end
    endtask

    task automatic t_extremes();
        for (int i = 0; i < D; i++) push(MINV, MINV);
        for (int i = 0; i < D; i++) begin
            push(MAXV, MINV);
            chk(int'(out_alpha) == MAXV, "R5 alpha top", int'(out_alpha), MAXV);
            chk(int'(out_beta) == MINV, "R5 beta bottom", int'(out_beta), MINV);
        end
        for (int i = 0; i < D; i++) push(MINV, MAXV);
    endtask

    task automatic t_unbalanced();
        real w, up, un, th, x, y, pe;
        int a, b, ref_a;
        w = 2.0 * 3.14159265358979 / real'(4 * D);
        up = 8000.0; un = 3000.0; th = 0.7;
        for (int i = 0; i < 6 * D; i++) begin
            x = up * $cos(w * i) + un * $cos(-w * i + th);
            y = up * $sin(w * i) + un * $sin(-w * i + th);
            a = $rtoi(x + ((x >= 0.0) ? 0.5 : -0.5));
            b = $rtoi(y + ((y >= 0.0) ? 0.5 : -0.5));
            push(a, b);
            if (out_valid) begin
                pe = up * $cos(w * i);
                ref_a = $rtoi(pe + ((pe >= 0.0) ? 0.5 : -0.5));
                chk((int'(out_alpha) - ref_a) <= 2 && (ref_a - int'(out_alpha)) <= 2,
                    "R10 positive sequence", int'(out_alpha), ref_a);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_and_ramp();   // R2 R6 R3 R4 R9
        t_gaps();            // R7 R1
        t_reset();           // R8 mid-run
        t_gaps();            // R2 refill after reset
        t_reset();
        t_extremes();        // R5
        t_reset();
        t_unbalanced();      // R10
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule